// File: doc/BRIEF.md
# UART Serial Transmitter with Holding Register or FIFO Staging

This block is the transmit half of a classic asynchronous serial port. Bytes arrive through a one-cycle write strobe. Each byte waits either in a single holding slot or in a queue whose depth is a parameter. A shifter sends each byte out as one framed character on the serial output. The shifter takes the next byte as soon as it goes idle. All bit timing comes from a 16x baud enable pulse, which an external divisor supplies.

Framing comes from a 7-bit line-control input and can change between characters. The input sets the data width (5 to 8 bits), parity (off, odd, even, or stuck at a fixed level), the stop length (1, 1.5 or 2 bits) and a break override. The framing is captured when a byte enters the shifter. The break override acts on the output at once. The status outputs report an empty holding stage, a fully drained transmitter, and a ready request for the host.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `txd` is 1 (mark), and `hold_empty`, `all_empty` and `tx_irq` are all 1.
- R2: A character is a 0 start bit, then data bits least significant first, then an optional parity bit, then stop bits at 1. Every start, data and parity bit lasts exactly 16 `tick16` pulses.
- R3: `line_ctl[1:0]` sets the data width to 5 + value bits (00 = 5, 11 = 8). Unused upper bits of `wr_data` are not sent.
- R4: When `line_ctl[3]` = 1, one parity bit follows the data. With `line_ctl[4]` = 1 the data plus parity bits hold an even count of ones. With `line_ctl[4]` = 0 the count is odd.
- R5: When `line_ctl[5]` = 1 and parity is enabled, the parity bit is the inverse of `line_ctl[4]`, whatever the data.
- R6: With `line_ctl[2]` = 0 the stop period is 16 ticks. With `line_ctl[2]` = 1 it is 24 ticks for 5-bit words and 32 ticks for any other width.
- R7: While `line_ctl[6]` = 1, `txd` is 0. The character timing and the status outputs go on unchanged.
- R8: With `fifo_mode` = 0 there is a single holding slot. A byte moves from it into the shifter only when the shifter is idle. A write while the slot is occupied and the shifter is busy is dropped.
- R9: With `fifo_mode` = 1, up to DEPTH (16) bytes queue and are sent in write order. A write to a full queue is dropped.
- R10: `fifo_clr` empties the queue in one cycle and outranks a write in the same cycle. A character already in the shifter still completes.
- R11: `hold_empty` and `tx_irq` are 1 exactly when no byte waits in the holding stage. `all_empty` is 1 only when, in addition, the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x baud enable, one clock wide |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| fifo_mode | input | 1 | 1 = queue staging, 0 = single holding slot |
| fifo_clr | input | 1 | Empty the holding stage |
| line_ctl | input | 7 | Framing: [1:0] width, [2] long stop, [3] parity on, [4] even, [5] stick, [6] break |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding stage empty |
| all_empty | output | 1 | Holding stage and shifter both empty |
| tx_irq | output | 1 | Transmit-ready request |

## Verification
Status outputs change one clock after the edge that accepts a write. A byte written into an empty transmitter enters the shifter on the following edge, so the start bit shows on `txd` two edges after the write strobe. Each `txd` level holds for exactly the number of `tick16` pulses its bit takes. The bench samples one time unit after each falling edge. It records `txd` only on cycles where `tick16` is high and will be consumed by the next rising edge, so a character yields one sample per tick. Stop-bit length is measured as the number of tick samples from the start bit until `all_empty` rises.

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_mode,
  input  logic       fifo_clr,
  input  logic [6:0] line_ctl,
  output logic       txd,
  output logic       hold_empty,
  output logic       all_empty,
  output logic       tx_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [15:0]   frame, nframe;
  logic [7:0]    tcnt, tend, ntend;

  wire [CW-1:0] cap  = fifo_mode ? CW'(DEPTH) : CW'(1);
  wire          pop  = !busy && (cnt != 0) && !fifo_clr;
  wire          push = wr_en && !fifo_clr && ((cnt < cap) || (pop && cnt == cap));

  wire [3:0] nbits = 4'd5 + {2'b00, line_ctl[1:0]};
  wire [7:0] dat   = mem[rd_p] & (8'hFF >> (2'd3 - line_ctl[1:0]));
  wire       par   = line_ctl[5] ? ~line_ctl[4] : ((^dat) ^ ~line_ctl[4]);
  wire [7:0] stopt = !line_ctl[2] ? 8'd16 : (line_ctl[1:0] == 2'b00 ? 8'd24 : 8'd32);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    nframe    = '1;
    nframe[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nbits)) nframe[i+1] = dat[i];
    if (line_ctl[3]) nframe[nbits + 4'd1] = par;
    ntend = {4'(nbits + 4'd1 + {3'b000, line_ctl[3]}), 4'b0000} + stopt;
  end

  always_ff @(posedge clk)
    if (push) mem[wr_p] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0; wr_p <= '0; cnt <= '0;
      busy <= 1'b0; frame <= '1; tcnt <= '0; tend <= '0;
    end else begin
      if (fifo_clr) begin
        rd_p <= '0; wr_p <= '0; cnt <= '0;
      end else begin
        if (push) wr_p <= nxt(wr_p);
        if (pop)  rd_p <= nxt(rd_p);
        cnt <= cnt + CW'(push) - CW'(pop);
      end
      if (pop) begin
        busy <= 1'b1; frame <= nframe; tend <= ntend; tcnt <= '0;
      end else if (busy && tick16) begin
        if (tcnt == tend - 8'd1) busy <= 1'b0;
        tcnt <= tcnt + 8'd1;
      end
    end
  end

  assign txd        = !line_ctl[6] && (!busy || frame[tcnt[7:4]]);
  assign hold_empty = (cnt == 0);
  assign all_empty  = hold_empty && !busy;
  assign tx_irq     = hold_empty;

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> hold_empty);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !line_ctl[6]) |-> !txd);
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && busy && !fifo_clr) |=> cnt == CW'(DEPTH));
  a_r6_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tcnt < tend);
endmodule

// File: tb/test_uart_tx_core.sv
`timescale 1ns/1ps
module test_uart_tx_core;
  logic clk = 0, rst_n = 0, tick16 = 0, wr_en = 0, fifo_mode = 0, fifo_clr = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] line_ctl = 0;
  logic txd, hold_empty, all_empty, tx_irq;
  int n_chk = 0, n_fail = 0, tick_div = 1, tdc = 0, cyc = 0;
  logic rec [256];
  int nrec;

  uart_tx_core i_uart_tx_core (.clk, .rst_n, .tick16, .wr_en, .wr_data, .fifo_mode,
    .fifo_clr, .line_ctl, .txd, .hold_empty, .all_empty, .tx_irq);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div == 0) tick16 <= 0;
    else begin
      tick16 <= (tdc == 0);
      tdc <= (tdc + 1 >= tick_div) ? 0 : tdc + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; #1;
  endtask

  task automatic record(input bit any);
    bit started = 0;
    nrec = 0;
    for (int g = 0; g < 4000; g++) begin
      step();
      if (started && all_empty) break;
      if (tick16 && (started || any || txd == 0)) begin
        started = 1;
        if (nrec < 256) rec[nrec] = txd;
        nrec++;
      end
    end
  endtask

  task automatic rx_char(output logic [7:0] d);
    int k = 0;
    d = 0;
    for (int g = 0; g < 6000; g++) begin
      step();
      if (tick16 && (k > 0 || txd == 0)) begin
        if (k >= 24 && k < 152 && (k % 16) == 8) d[(k - 24) / 16] = txd;
        if (k == 152) begin
          check(txd == 1, "R2 stop", txd, 1);
          return;
        end
        k++;
      end
    end
  endtask

  task automatic frame_test(input logic [6:0] lc, input logic [7:0] d);
    int n, p, st, L, ones, pb, md, mp, ms;
    logic eb [16];
    line_ctl = lc;
    n = 5 + lc[1:0]; p = lc[3];
    st = !lc[2] ? 16 : (n == 5 ? 24 : 32);
    L = 16 * (1 + n + p) + st;
    ones = 0;
    for (int i = 0; i < 16; i++) eb[i] = 1;
    eb[0] = 0;
    for (int i = 0; i < n; i++) begin eb[i+1] = d[i]; ones += d[i]; end
    pb = lc[5] ? !lc[4] : (lc[4] ? ones % 2 : 1 - ones % 2);
    if (p) eb[n+1] = pb[0];
    wr(d);
    record(0);
    md = 0; mp = 0; ms = 0;
    for (int k = 0; k < nrec && k < 256; k++) begin
      if (k < 16 * (1 + n)) md += (rec[k] != eb[k / 16]);
      else if (p && k < 16 * (2 + n)) mp += (rec[k] != eb[k / 16]);
      else ms += (rec[k] != 1);
    end
    check(nrec == L, "R6 length", nrec, L);
    check(md == 0, "R3 start/data", md, 0);
    if (p) check(mp == 0, lc[5] ? "R5 stick" : "R4 parity", mp, 0);
    check(ms == 0, "R2 stop level", ms, 0);
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] dv [3] = '{8'hA7, 8'h5E, 8'hFF};
    int pm_par [5] = '{0, 1, 1, 1, 1};
    int pm_evn [5] = '{0, 0, 1, 0, 1};
    int pm_stk [5] = '{0, 0, 0, 1, 1};
    step();
    check(txd == 1, "R1 txd", txd, 1);
    check(hold_empty && all_empty && tx_irq, "R1 status",
          {hold_empty, all_empty, tx_irq}, 7);
    rst_n = 1;
    step();

    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 5; m++)
          for (int v = 0; v < 3; v++)
            frame_test({1'b0, 1'(pm_stk[m]), 1'(pm_evn[m]), 1'(pm_par[m]), 1'(s), 2'(w)}, dv[v]);

    tick_div = 3;
    frame_test(7'b0011011, 8'h96);
    frame_test(7'b0101100, 8'h13);
    tick_div = 1;

    line_ctl = 7'b1000011;
    step();
    check(txd == 0, "R7 idle break", txd, 0);
    wr(8'h55);
    record(1);
    check(nrec == 160, "R7 timing", nrec, 160);
    begin
      int ones = 0;
      for (int k = 0; k < 160; k++) ones += rec[k];
      check(ones == 0, "R7 low", ones, 0);
    end
    line_ctl = 7'b0000011;
    step();
    check(txd == 1, "R7 release", txd, 1);

    tick_div = 0;
    fifo_mode = 0;
    wr(8'h11); wr(8'h22); wr(8'h33);
    check(!hold_empty && !tx_irq, "R11 occupied", hold_empty, 0);
    tick_div = 1;
    rx_char(got); check(got == 8'h11, "R8 first", got, 8'h11);
    rx_char(got); check(got == 8'h22, "R8 second", got, 8'h22);
    record(0);
    check(nrec == 0 && all_empty, "R8 drop", nrec, 0);

    tick_div = 0;
    fifo_mode = 1;
    for (int i = 0; i < 18; i++) wr(8'h30 + 8'(i));
    check(!hold_empty, "R9 full", hold_empty, 0);
    tick_div = 1;
    for (int i = 0; i < 17; i++) begin
      rx_char(got);
      check(got == 8'h30 + 8'(i), "R9 order", got, 8'h30 + i);
    end
    record(0);
    check(nrec == 0 && all_empty, "R9 drop", nrec, 0);

    tick_div = 0;
    for (int i = 0; i < 5; i++) wr(8'hC0 + 8'(i));
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0; #1;
    check(hold_empty && tx_irq, "R10 cleared", hold_empty, 1);
    check(!all_empty, "R11 shifter busy", all_empty, 0);
    @(negedge clk); fifo_clr = 1; wr_en = 1; wr_data = 8'hEE;
    @(negedge clk); fifo_clr = 0; wr_en = 0; #1;
    check(hold_empty, "R10 clear wins", hold_empty, 1);
    tick_div = 1;
    rx_char(got); check(got == 8'hC0, "R10 in-flight", got, 8'hC0);
    record(0);
    check(nrec == 0 && all_empty && tx_irq, "R11 drained", nrec, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule